// File: doc/BRIEF.md
# Time-Stamped Trace Event Merger

This block gathers event pulses from a configurable number of hardware monitor ports (1 to 63) and from software. Each monitor port carries a one-cycle event pulse and a start/stop qualifier. Typical sources are an accelerator start edge or done pulse, or the first and last beat of a stream transfer. Software raises events by writing to an AXI4-Lite slave, and each write becomes exactly one event. One free-running 64-bit counter stamps every event, whether it came from hardware or software, so the two kinds of event can be placed on a single time line.

Each event is caught in a one-entry pending slot that belongs to its source. Source 0 is software and source k+1 is monitor port k. A priority picker moves the pending entry with the lowest source number into an internal FIFO, one entry per cycle. Events that arrive in the same cycle therefore come out in ascending source order, and each keeps the stamp of the cycle in which it was caught. The FIFO is read through a ready/valid record port. A lost event sets a sticky overflow bit. Software reads this bit and clears it by writing 1 to it.

Top module: `trace_aggregator`

## Requirements
- R1: A 64-bit timestamp counter is 0 in reset and advances by one on every clock edge after reset. An event's record carries the counter value of the cycle in which its pulse, or its write handshake, is sampled.
- R2: A record is 95 bits wide: bits 94:31 hold the timestamp, bits 30:25 the source ID, bit 24 the start flag (1 = start, 0 = stop) and bits 23:0 the payload.
- R3: A pulse on `mon_evt[k]` produces one record with source ID k+1, start flag `mon_start[k]` and payload 0.
- R4: A write to address 0x0 produces one record with source ID 0, start flag `wdata[31]` and payload `wdata[23:0]`. Every accepted write gets an OKAY response (`bresp` = 0), including a write whose event is lost.
- R5: Events sampled in the same cycle come out in ascending source ID order, and all of them carry that cycle's timestamp.
- R6: An event on a source whose pending slot holds an entry that is not being moved out in that cycle is dropped and sets the overflow bit. The held entry is delivered unchanged.
- R7: While the FIFO is full, every arriving event is dropped and sets the overflow bit. The records already stored are delivered intact and in order.
- R8: The overflow bit reads as bit 0 at address 0x4 and stays set until it is cleared. A write to 0x4 with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it unchanged.
- R9: `rec_valid` is low after reset. While `rec_valid` is high and `rec_ready` is low, `rec_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_evt | input | NUM_MON | One-cycle event pulse per monitor port |
| mon_start | input | NUM_MON | Start (1) or stop (0) qualifier per port |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| rec_valid | output | 1 | Trace record available |
| rec_ready | input | 1 | Reader accepts the record |
| rec_data | output | 95 | Trace record |

## Verification
The assertions check several properties on every cycle. No record leaves for the FIFO while the FIFO is full. A moved record is always stamped earlier than the current count. Any drop raises the overflow bit, which stays up until a clear. Accepted writes are answered, and a stalled output record holds steady. Some behaviours appear only in the bench's scenarios: the exact stamp values, the ascending order when many sources fire in one cycle, which event of a colliding pair survives, and the exact record count kept when the FIFO fills. The bench fires every combination of software and port events to cover these.

// File: rtl/trace_agg_pkg.sv
package trace_agg_pkg;
  localparam int TS_W    = 64;
  localparam int SRC_W   = 6;
  localparam int PAY_W   = 24;
  localparam int REC_W   = TS_W + SRC_W + 1 + PAY_W;
  localparam int MAX_SRC = 64;

  // Record layout: {timestamp, source, start flag, payload}
  function automatic logic [REC_W-1:0] pack_rec(input logic [TS_W-1:0] ts,
                                               input logic [SRC_W-1:0] src,
                                               input logic start,
                                               input logic [PAY_W-1:0] pay);
    return {ts, src, start, pay};
  endfunction

  // Index of the lowest set bit (0 when none set)
  function automatic logic [SRC_W-1:0] first_set(input logic [MAX_SRC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = SRC_W'(i);
    end
    return r;
  endfunction

  function automatic logic [TS_W-1:0] ts_next(input logic [TS_W-1:0] t);
    return t + 1'b1;
  endfunction
endpackage

// File: rtl/trace_pending.sv
module trace_pending
  import trace_agg_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TS_W-1:0]    ts,
  input  logic [NUM_SRC-1:0] ev_hit,
  input  logic [NUM_SRC-1:0] ev_start,
  input  logic [PAY_W-1:0]   sw_pay,
  input  logic               fifo_full,
  output logic               push,
  output logic [REC_W-1:0]   push_rec,
  output logic               drop_any
);
  logic [NUM_SRC-1:0] pend_v;
  logic [NUM_SRC-1:0] pend_flag;
  logic [TS_W-1:0]    pend_ts [NUM_SRC];
  logic [PAY_W-1:0]   pay_q;
  logic [MAX_SRC-1:0] pend_pad;
  logic [SRC_W-1:0]   sel_idx;
  logic [NUM_SRC-1:0] gnt;
  logic [NUM_SRC-1:0] cap;
  logic [NUM_SRC-1:0] drop;
  logic [TS_W-1:0]    sel_ts;
  logic               sel_flag;

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_SRC-1:0] = pend_v;
  end

  assign sel_idx = first_set(pend_pad);
  assign push    = (|pend_v) && !fifo_full;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    assign gnt[i]  = push && (sel_idx == SRC_W'(i));
    assign cap[i]  = ev_hit[i] && !fifo_full && (!pend_v[i] || gnt[i]);
    assign drop[i] = ev_hit[i] && !cap[i];
  end

  assign drop_any = |drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= '0;
      pend_flag <= '0;
      pay_q     <= '0;
      for (int i = 0; i < NUM_SRC; i++) pend_ts[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cap[i]) begin
          pend_v[i]    <= 1'b1;
          pend_flag[i] <= ev_start[i];
          pend_ts[i]   <= ts;
        end else if (gnt[i]) begin
          pend_v[i] <= 1'b0;
        end
      end
      if (cap[0]) pay_q <= sw_pay;
    end
  end

  always_comb begin
    sel_ts   = '0;
    sel_flag = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (gnt[i]) begin
        sel_ts   = sel_ts | pend_ts[i];
        sel_flag = sel_flag | pend_flag[i];
      end
    end
  end

  assign push_rec = pack_rec(sel_ts, sel_idx, sel_flag, gnt[0] ? pay_q : '0);
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int WIDTH = 95,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rd_ptr];
  assign do_push  = push && !full;
  assign do_pop   = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/trace_axil.sv
module trace_axil #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [31:0]       wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  input  logic              ovf,
  output logic              wr_go,
  output logic              sw_hit,
  output logic              ovf_clr
);
  logic rd_go;

  assign wr_go   = awvalid && wvalid && !bvalid;
  assign awready = wr_go;
  assign wready  = wr_go;
  assign sw_hit  = wr_go && (awaddr == ADDR_W'(0));
  assign ovf_clr = wr_go && (awaddr == ADDR_W'(4)) && wdata[0];
  assign bresp   = 2'b00;

  assign rd_go   = arvalid && !rvalid;
  assign arready = rd_go;
  assign rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_go)       bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;
      if (rd_go) begin
        rvalid <= 1'b1;
        rdata  <= (araddr == ADDR_W'(4)) ? {31'b0, ovf} : 32'b0;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trace_aggregator.sv
module trace_aggregator
  import trace_agg_pkg::*;
#(
  parameter int NUM_MON    = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_evt,
  input  logic [NUM_MON-1:0] mon_start,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_wvalid,
  output logic               s_wready,
  input  logic [31:0]        s_wdata,
  output logic               s_bvalid,
  input  logic               s_bready,
  output logic [1:0]         s_bresp,
  input  logic               s_arvalid,
  output logic               s_arready,
  input  logic [ADDR_W-1:0]  s_araddr,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [31:0]        s_rdata,
  output logic [1:0]         s_rresp,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic [94:0]        rec_data
);
  localparam int NUM_SRC = NUM_MON + 1;

  logic [TS_W-1:0]    ts_q;
  logic               ovf_q;
  logic               wr_go, sw_hit, ovf_clr;
  logic [NUM_SRC-1:0] ev_hit, ev_start;
  logic               push, fifo_full, drop_any;
  logic [REC_W-1:0]   push_rec;
  logic [TS_W-1:0]    push_ts;
  logic               wdata_unused;

  assign wdata_unused = ^s_wdata[30:24];
  assign ev_hit   = {mon_evt, sw_hit};
  assign ev_start = {mon_start, s_wdata[31]};
  assign push_ts  = push_rec[REC_W-1 -: TS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_next(ts_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (drop_any) ovf_q <= 1'b1;
    else if (ovf_clr)  ovf_q <= 1'b0;
  end

  trace_axil #(.ADDR_W(ADDR_W)) u_axil (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .ovf(ovf_q), .wr_go(wr_go), .sw_hit(sw_hit), .ovf_clr(ovf_clr)
  );

  trace_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .ts(ts_q),
    .ev_hit(ev_hit), .ev_start(ev_start), .sw_pay(s_wdata[PAY_W-1:0]),
    .fifo_full(fifo_full), .push(push), .push_rec(push_rec), .drop_any(drop_any)
  );

  trace_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(push_rec),
    .full(fifo_full), .rd_valid(rec_valid), .rd_ready(rec_ready), .rd_data(rec_data)
  );
endmodule

// File: rtl/trace_aggregator_checker.sv
module trace_aggregator_checker
  import trace_agg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [TS_W-1:0]  ts,
  input logic             push,
  input logic [TS_W-1:0]  push_ts,
  input logic             fifo_full,
  input logic             drop_any,
  input logic             ovf,
  input logic             ovf_clr,
  input logic             wr_go,
  input logic             bvalid,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [REC_W-1:0] rec_data
);
  a_r1_stamp_in_past: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> push_ts < ts);
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push);
  a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    drop_any |=> ovf);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  a_r8_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !drop_any |=> !ovf);
  a_r4_write_answered: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> bvalid);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));
endmodule

bind trace_aggregator trace_aggregator_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ts(ts_q), .push(push), .push_ts(push_ts),
  .fifo_full(fifo_full), .drop_any(drop_any), .ovf(ovf_q), .ovf_clr(ovf_clr),
  .wr_go(wr_go), .bvalid(s_bvalid), .rec_valid(rec_valid),
  .rec_ready(rec_ready), .rec_data(rec_data)
);

// File: tb/trace_aggregator_test.sv
`timescale 1ns/1ps
module trace_aggregator_test;
  localparam int NMON = 4;
  localparam int DEP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NMON-1:0] mon_evt = '0, mon_start = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1, rec_ready = 0;
  logic [3:0] awaddr = '0, araddr = '0;
  logic [31:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid, rec_valid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [94:0] rec_data;

  logic [63:0] cyc = '0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [94:0] exp_q [16];
  int eh = 0, et = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 64'd0;

  trace_aggregator #(.NUM_MON(NMON), .FIFO_DEPTH(DEP), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .mon_evt(mon_evt), .mon_start(mon_start),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2 layout: ts[94:31] src[30:25] start[24] payload[23:0]
  task automatic push_exp(input logic [63:0] t, input logic [5:0] s, input logic st, input logic [23:0] p);
    exp_q[et] = {t, s, st, p};
    et++;
  endtask

  // Called at a negedge; returns one negedge later.
  task automatic fire(input logic [3:0] hw, input logic [3:0] hs, input bit sw,
                      input logic [31:0] swd, input bit keep);
    logic [63:0] t;
    t = cyc;
    mon_evt = hw; mon_start = hs;
    if (sw) begin awvalid = 1; wvalid = 1; awaddr = 4'h0; wdata = swd; end
    if (keep) begin
      if (sw) push_exp(t, 6'd0, swd[31], swd[23:0]);
      for (int i = 0; i < NMON; i++) if (hw[i]) push_exp(t, 6'(i + 1), hs[i], 24'd0);
    end
    @(negedge clk);
    mon_evt = '0; mon_start = '0; awvalid = 0; wvalid = 0;
    if (sw) chk(bvalid && bresp == 2'b00, "R4 write response", {bvalid, bresp}, 3'b100);
  endtask

  task automatic axw(input logic [3:0] a, input logic [31:0] d);
    awvalid = 1; wvalid = 1; awaddr = a; wdata = d;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk(bvalid && bresp == 2'b00, "R4 write response", {bvalid, bresp}, 3'b100);
  endtask

  task automatic axr(input logic [3:0] a, output logic [31:0] d);
    arvalid = 1; araddr = a;
    @(negedge clk);
    arvalid = 0;
    chk(rvalid, "R8 read response", rvalid, 1);
    d = rdata;
  endtask

  task automatic drain(input string req);
    int guard;
    guard = 0;
    rec_ready = 1;
    while (eh < et && guard < 200) begin
      if (rec_valid) begin
        chk(rec_data == exp_q[eh], req, rec_data, exp_q[eh]);
        eh++;
      end
      @(negedge clk);
      guard++;
    end
    rec_ready = 0;
    if (eh < et) chk(0, {req, " missing record"}, eh, et);
    repeat (4) @(negedge clk);
    chk(!rec_valid, {req, " no extra record"}, rec_valid, 0);
    eh = 0; et = 0;
  endtask

  initial begin
    logic [31:0] rd;
    logic [94:0] held;
    repeat (3) @(negedge clk);
    chk(!rec_valid, "R9 no record in reset", rec_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rec_valid && !bvalid && !rvalid, "R9 idle after reset", {rec_valid, bvalid, rvalid}, 0);
    axr(4'h4, rd);
    chk(rd == 0, "R8 overflow clear after reset", rd, 0);

    // R1 R3 R4 R5 sweep: every combination of sw + 4 ports in one cycle
    for (int p = 0; p < 32; p++) begin
      logic [3:0] hw, hs;
      logic [31:0] swd;
      hw  = p[3:0];
      hs  = p[3:0] ^ 4'b1010;
      swd = {p[1], 7'h33, 24'hA50000 | 24'(p)};
      fire(hw, hs, p[4], swd, 1);
      drain("R1 R2 R3 R4 R5 record");
    end
    axr(4'h4, rd);
    chk(rd == 0, "R8 no overflow after sweep", rd, 0);

    // R6: refire port 3 while its slot still waits
    fire(4'b1111, 4'b1111, 1, 32'h8000_0011, 1);
    fire(4'b1000, 4'b0000, 0, 32'h0, 0);
    drain("R6 colliding event dropped");
    axr(4'h4, rd);
    chk(rd == 1, "R6 overflow set by collision", rd, 1);
    axw(4'h4, 32'h0);
    axr(4'h4, rd);
    chk(rd == 1, "R8 write of 0 keeps overflow", rd, 1);
    axw(4'h4, 32'h1);
    axr(4'h4, rd);
    chk(rd == 0, "R8 write of 1 clears overflow", rd, 0);

    // R7: fill the FIFO with no reader
    for (int k = 0; k < 10; k++) begin
      if (k < 9) fire(4'b0010, {2'b0, k[0], 1'b0}, 0, 32'h0, k < DEP);
      else       fire(4'b0000, 4'b0000, 1, 32'h8012_3456, 0);
      repeat (2) @(negedge clk);
    end
    chk(rec_valid && rec_data == exp_q[0], "R7 first stored record", rec_data, exp_q[0]);
    held = rec_data;
    repeat (3) @(negedge clk);
    chk(rec_valid && rec_data == held, "R9 stalled record held", rec_data, held);
    axr(4'h4, rd);
    chk(rd == 1, "R7 overflow set when full", rd, 1);
    drain("R7 stored records intact");
    axw(4'h4, 32'h1);
    axr(4'h4, rd);
    chk(rd == 0, "R8 cleared after full test", rd, 0);

    // R1: isolated software event after idle time
    repeat (7) @(negedge clk);
    fire(4'b0000, 4'b0000, 1, 32'h0000_BEEF, 1);
    drain("R1 R4 software stamp");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule